// File: doc/BRIEF.md
# Sub-Tick Word Demultiplexer and Aligner

This block sits behind a decoded serial link that delivers one 32-bit word, with one control flag per byte, on a fast clock running at four times the bunch clock. Every bunch tick is carried as four consecutive words (slices). The link never idles and carries no framing. The only timing reference is a marker word. This is an all-control word that stands in for a zero-valued slice 0. The block uses where the marker falls to find the slice phase. It counts how consistently the marker falls on slice 0 to declare and drop lock. It packs each tick's four slices into one wide word and passes that word through a small dual-clock buffer into the bunch-clock domain. There, data from many links can be combined tick by tick.

Any all-control word built from the marker byte or the filler byte is turned back into a zero data word. Other words pass unchanged. Two saturating counters record lock losses and link code/disparity error flags. A synchronous clear input resets both counters. Lock, the counters and the clear input belong to the fast-clock domain. The wide word and its valid strobe belong to the bunch-clock domain.

Top module: `lnk_tick_aligner`

## Requirements
- R1: While reset is held low, `locked` is 0, `tick_vld` is 0, and `loss_cnt` and `err_cnt` are 0.
- R2: The marker is a word with all four control flags set and every byte equal to 0xBC. Lock is declared once `lock_ticks` consecutive markers have fallen on slice 0, and not before.
- R3: While unlocked, a marker seen in any slice other than 0 re-phases the slice counter so that the marker word becomes slice 0. The consecutive count restarts at one. Ticks packed after the relock are aligned to the new phase.
- R4: While locked, LOSS_LIMIT consecutive markers outside slice 0 (default 3) clear `locked`. A marker on slice 0 resets that run, so fewer than LOSS_LIMIT misplaced markers in a row keep lock.
- R5: Each loss of lock adds one to `loss_cnt`.
- R6: While locked, each tick yields one `tick_vld` word in the bunch-clock domain, in arrival order. Slice k occupies bits 32k+31 down to 32k, and slice 0 is the word that follows the marker phase.
- R7: A word whose four control flags are all set and whose bytes are all 0xBC, or all 0x3C, is delivered as zero. Every other word, including 0x3C3C3C3C with no flags and 0xBCBCBCBC with flags 0111, is delivered unchanged.
- R8: `err_cnt` rises by one for every fast-clock word with `lnk_err` high, and it saturates at its maximum (255 by default).
- R9: A `cnt_clr` pulse zeroes both counters on the next fast edge, even when an error or loss occurs in the same cycle.
- R10: The clock-crossing buffer never overwrites a word that has not yet been read. Each word written is read exactly once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fclk | input | 1 | Link word clock (four times bunch rate) |
| sclk | input | 1 | Bunch clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| lnk_word | input | 32 | Decoded link word |
| lnk_ctrl | input | 4 | Per-byte control flags of `lnk_word` |
| lnk_err | input | 1 | Code or disparity error on this word |
| lock_ticks | input | 4 | Consecutive aligned markers needed for lock |
| cnt_clr | input | 1 | Synchronous clear of both counters (fclk) |
| tick_data | output | 128 | Packed tick, slice 0 in the low bits (sclk) |
| tick_vld | output | 1 | `tick_data` holds a new tick (sclk) |
| locked | output | 1 | Slice phase locked (fclk) |
| loss_cnt | output | 8 | Saturating count of lock losses (fclk) |
| err_cnt | output | 8 | Saturating count of flagged words (fclk) |

## Verification
Several properties are checked on every fast or slow edge. The slice counter steps by one on every cycle that stays locked. Lock can only rise right after a marker. Each fall of lock bumps the loss counter. The error counter only moves upward between clears, and a clear empties both counters. The write side of the buffer never gets a full buffer ahead of the read side.

Some behaviour only the directed scenarios can show. These cover the exact number of markers needed before lock, the re-phase that follows a shifted stream, and tolerance of isolated misplaced markers. They also cover the slice order inside the packed word after the crossing, the zero restoration of both comma forms against look-alike words, and counter saturation.

// File: rtl/lnk_align_pkg.sv
package lnk_align_pkg;
   // byte values used to build all-control words
   localparam logic [7:0] K_MARK = 8'hBC;  // tick start marker byte
   localparam logic [7:0] K_FILL = 8'h3C;  // zero-standin byte in other slices
endpackage

// File: rtl/lnk_slice_pack.sv
module lnk_slice_pack
   import lnk_align_pkg::*;
#(
   parameter int W = 32,
   parameter int N = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [W-1:0]         word_i,
   input  logic [W/8-1:0]       ctrl_i,
   input  logic [$clog2(N)-1:0] slice_i,
   output logic                 mark_o,
   output logic [W*N-1:0]       wide_o
);
   localparam int NB = W / 8;
   localparam int SW = $clog2(N);

   logic          all_k;
   logic          is_mark;
   logic          is_fill;
   logic [W-1:0]  plain;

   assign all_k   = &ctrl_i;
   assign is_mark = all_k && (word_i == {NB{K_MARK}});
   assign is_fill = all_k && (word_i == {NB{K_FILL}});
   assign plain   = (is_mark || is_fill) ? '0 : word_i;
   assign mark_o  = is_mark;

   // slices 0..N-2 are held; the last slice is taken straight from the link
   for (genvar s = 0; s < N - 1; s++) begin : g_slot
      logic [W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                q <= '0;
         else if (slice_i == SW'(s)) q <= plain;
      end
      assign wide_o[s*W +: W] = q;
   end
   assign wide_o[(N-1)*W +: W] = plain;
endmodule

// File: rtl/lnk_aln_ctrl.sv
module lnk_aln_ctrl #(
   parameter int N          = 4,
   parameter int LOCK_W     = 4,
   parameter int LOSS_LIMIT = 3,
   parameter int CNT_W      = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 mark_i,
   input  logic                 err_i,
   input  logic                 clr_i,
   input  logic [LOCK_W-1:0]    need_i,
   output logic [$clog2(N)-1:0] slice_o,
   output logic                 locked_o,
   output logic                 tick_end_o,
   output logic [CNT_W-1:0]     loss_cnt_o,
   output logic [CNT_W-1:0]     err_cnt_o
);
   localparam int SW = $clog2(N);
   localparam int GW = LOCK_W + 1;
   localparam int BW = (LOSS_LIMIT > 1) ? $clog2(LOSS_LIMIT) + 1 : 1;

   logic [SW-1:0]    slice_q;
   logic             locked_q;
   logic [GW-1:0]    good_q;
   logic [GW-1:0]    good_nx;
   logic [GW-1:0]    need;
   logic [BW-1:0]    bad_q;
   logic [CNT_W-1:0] loss_q;
   logic [CNT_W-1:0] err_q;
   logic             at_zero;
   logic             lost;

   assign at_zero = (slice_q == '0);
   assign need    = (need_i == '0) ? GW'(1) : GW'(need_i);
   assign good_nx = at_zero ? good_q + GW'(1) : GW'(1);
   assign lost    = mark_i && locked_q && !at_zero && (bad_q == BW'(LOSS_LIMIT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slice_q  <= '0;
         locked_q <= 1'b0;
         good_q   <= '0;
         bad_q    <= '0;
      end else begin
         slice_q <= slice_q + SW'(1);
         if (mark_i) begin
            if (!locked_q) begin
               if (!at_zero) slice_q <= SW'(1);
               good_q <= good_nx;
               if (good_nx >= need) locked_q <= 1'b1;
            end else if (at_zero) begin
               bad_q <= '0;
            end else if (lost) begin
               locked_q <= 1'b0;
               good_q   <= '0;
               bad_q    <= '0;
            end else begin
               bad_q <= bad_q + BW'(1);
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         loss_q <= '0;
         err_q  <= '0;
      end else if (clr_i) begin
         loss_q <= '0;
         err_q  <= '0;
      end else begin
         if (lost && !(&loss_q)) loss_q <= loss_q + CNT_W'(1);
         if (err_i && !(&err_q)) err_q <= err_q + CNT_W'(1);
      end
   end

   assign slice_o    = slice_q;
   assign locked_o   = locked_q;
   assign tick_end_o = locked_q && (slice_q == SW'(N - 1));
   assign loss_cnt_o = loss_q;
   assign err_cnt_o  = err_q;

   // R2
   lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked_q) |-> $past(mark_i));
   // R6
   phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (locked_q && $past(locked_q)) |-> (slice_q == SW'($past(slice_q) + SW'(1))));
   // R5
   loss_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(locked_q) && !$past(clr_i)) |-> ((loss_q == CNT_W'($past(loss_q) + CNT_W'(1))) || (&$past(loss_q))));
   // R8
   err_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_i |=> (err_q >= $past(err_q)));
   // R9
   clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> ((loss_q == '0) && (err_q == '0)));
endmodule

// File: rtl/lnk_tick_cdc.sv
module lnk_tick_cdc #(
   parameter int DW    = 128,
   parameter int DEPTH = 4,
   parameter int SYNC  = 2
) (
   input  logic          wclk,
   input  logic          rclk,
   input  logic          rst_n,
   input  logic          wr_i,
   input  logic [DW-1:0] wdata_i,
   output logic [DW-1:0] rdata_o,
   output logic          rvld_o
);
   localparam int AW = $clog2(DEPTH);
   localparam int PW = AW + 1;

   logic [DW-1:0]            mem [DEPTH];
   logic [PW-1:0]            wptr, wnext, wgray;
   logic [PW-1:0]            rptr, rnext, rgray;
   logic [SYNC-1:0][PW-1:0]  wsync;
   logic [SYNC-1:0][PW-1:0]  rsync;
   logic [PW-1:0]            wbin_r;
   logic [PW-1:0]            rbin_w;

   assign wnext = wptr + PW'(1);
   assign rnext = rptr + PW'(1);

   always_comb begin
      for (int i = 0; i < PW; i++) begin
         wbin_r[i] = ^(wsync[SYNC-1] >> i);
         rbin_w[i] = ^(rsync[SYNC-1] >> i);
      end
   end

   always_ff @(posedge wclk) begin
      if (wr_i) mem[wptr[AW-1:0]] <= wdata_i;
   end

   always_ff @(posedge wclk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         wgray <= '0;
         rsync <= '0;
      end else begin
         rsync <= {rsync[SYNC-2:0], rgray};
         if (wr_i) begin
            wptr  <= wnext;
            wgray <= wnext ^ (wnext >> 1);
         end
      end
   end

   always_ff @(posedge rclk or negedge rst_n) begin
      if (!rst_n) begin
         rptr    <= '0;
         rgray   <= '0;
         wsync   <= '0;
         rdata_o <= '0;
         rvld_o  <= 1'b0;
      end else begin
         wsync <= {wsync[SYNC-2:0], wgray};
         if (rptr != wbin_r) begin
            rdata_o <= mem[rptr[AW-1:0]];
            rvld_o  <= 1'b1;
            rptr    <= rnext;
            rgray   <= rnext ^ (rnext >> 1);
         end else begin
            rvld_o <= 1'b0;
         end
      end
   end

   // R10
   no_overflow_chk: assert property (@(posedge wclk) disable iff (!rst_n)
      wr_i |-> (PW'(wptr - rbin_w) < PW'(DEPTH)));
endmodule

// File: rtl/lnk_tick_aligner.sv
module lnk_tick_aligner #(
   parameter int WORD_W      = 32,
   parameter int SLICES      = 4,
   parameter int LOCK_W      = 4,
   parameter int LOSS_LIMIT  = 3,
   parameter int CNT_W       = 8,
   parameter int FIFO_DEPTH  = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                     fclk,
   input  logic                     sclk,
   input  logic                     rst_n,
   input  logic [WORD_W-1:0]        lnk_word,
   input  logic [WORD_W/8-1:0]      lnk_ctrl,
   input  logic                     lnk_err,
   input  logic [LOCK_W-1:0]        lock_ticks,
   input  logic                     cnt_clr,
   output logic [WORD_W*SLICES-1:0] tick_data,
   output logic                     tick_vld,
   output logic                     locked,
   output logic [CNT_W-1:0]         loss_cnt,
   output logic [CNT_W-1:0]         err_cnt
);
   localparam int SW   = $clog2(SLICES);
   localparam int WIDE = WORD_W * SLICES;

   if (WORD_W % 8 != 0 || WORD_W < 8) begin : g_bad_word
      $error("WORD_W must be a whole number of bytes");
   end
   if (SLICES < 2 || (1 << SW) != SLICES) begin : g_bad_slices
      $error("SLICES must be a power of two of at least 2");
   end
   if (FIFO_DEPTH < 2 || (1 << $clog2(FIFO_DEPTH)) != FIFO_DEPTH) begin : g_bad_depth
      $error("FIFO_DEPTH must be a power of two of at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (LOSS_LIMIT < 1 || LOCK_W < 1 || CNT_W < 1) begin : g_bad_cnt
      $error("LOSS_LIMIT, LOCK_W and CNT_W must be positive");
   end

   logic            mark;
   logic [SW-1:0]   slice;
   logic            tick_end;
   logic [WIDE-1:0] wide;

   lnk_slice_pack #(.W(WORD_W), .N(SLICES)) u_pack (
      .clk    (fclk),
      .rst_n  (rst_n),
      .word_i (lnk_word),
      .ctrl_i (lnk_ctrl),
      .slice_i(slice),
      .mark_o (mark),
      .wide_o (wide)
   );

   lnk_aln_ctrl #(.N(SLICES), .LOCK_W(LOCK_W), .LOSS_LIMIT(LOSS_LIMIT), .CNT_W(CNT_W)) u_ctrl (
      .clk       (fclk),
      .rst_n     (rst_n),
      .mark_i    (mark),
      .err_i     (lnk_err),
      .clr_i     (cnt_clr),
      .need_i    (lock_ticks),
      .slice_o   (slice),
      .locked_o  (locked),
      .tick_end_o(tick_end),
      .loss_cnt_o(loss_cnt),
      .err_cnt_o (err_cnt)
   );

   lnk_tick_cdc #(.DW(WIDE), .DEPTH(FIFO_DEPTH), .SYNC(SYNC_STAGES)) u_cdc (
      .wclk   (fclk),
      .rclk   (sclk),
      .rst_n  (rst_n),
      .wr_i   (tick_end),
      .wdata_i(wide),
      .rdata_o(tick_data),
      .rvld_o (tick_vld)
   );
endmodule

// File: tb/test_lnk_tick_aligner.sv
module test_lnk_tick_aligner;
   typedef struct packed {
      logic [31:0] d;
      logic [3:0]  k;
      logic        e;
   } wd_t;

   localparam wd_t MARKW = '{d: 32'hBCBCBCBC, k: 4'hF, e: 1'b0};
   localparam wd_t FILLW = '{d: 32'h3C3C3C3C, k: 4'hF, e: 1'b0};

   logic         fclk = 1'b0;
   logic         sclk = 1'b0;
   logic         rst_n = 1'b0;
   logic [31:0]  lnk_word = '0;
   logic [3:0]   lnk_ctrl = '0;
   logic         lnk_err = 1'b0;
   logic [3:0]   lock_ticks = 4'd3;
   logic         cnt_clr = 1'b0;
   logic [127:0] tick_data;
   logic         tick_vld;
   logic         locked;
   logic [7:0]   loss_cnt;
   logic [7:0]   err_cnt;

   int           n_chk = 0;
   int           n_fail = 0;
   logic         drv_en = 1'b0;
   wd_t          txq[$];
   logic [127:0] rxq[$];

   lnk_tick_aligner i_lnk_tick_aligner (
      .fclk(fclk), .sclk(sclk), .rst_n(rst_n),
      .lnk_word(lnk_word), .lnk_ctrl(lnk_ctrl), .lnk_err(lnk_err),
      .lock_ticks(lock_ticks), .cnt_clr(cnt_clr),
      .tick_data(tick_data), .tick_vld(tick_vld),
      .locked(locked), .loss_cnt(loss_cnt), .err_cnt(err_cnt)
   );

   initial forever #4 fclk = ~fclk;
   initial forever #16 sclk = ~sclk;

   function automatic wd_t mk(input logic [31:0] d, input logic [3:0] k, input logic e);
      mk = '{d: d, k: k, e: e};
   endfunction

   function automatic void push_tick(input wd_t a, input wd_t b, input wd_t c, input wd_t d);
      txq.push_back(a); txq.push_back(b); txq.push_back(c); txq.push_back(d);
   endfunction

   // link driver: the stream never idles, filler ticks fill gaps
   initial begin
      forever begin
         @(negedge fclk);
         if (drv_en) begin
            wd_t w;
            if (txq.size() == 0) push_tick(MARKW, FILLW, FILLW, FILLW);
            w = txq.pop_front();
            lnk_word = w.d;
            lnk_ctrl = w.k;
            lnk_err  = w.e;
         end
      end
   end

   // bunch-clock side collector
   initial begin
      forever begin
         @(negedge sclk);
         if (tick_vld) rxq.push_back(tick_data);
      end
   end

   task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic drain();
      do @(posedge fclk); while (txq.size() != 0);
      @(negedge fclk);
   endtask

   task automatic pulse_clr();
      @(negedge fclk) cnt_clr = 1'b1;
      @(negedge fclk) cnt_clr = 1'b0;
   endtask

   task automatic chk_seq(input string req, input logic [127:0] exp[$]);
      int at = -1;
      for (int i = 0; i < rxq.size(); i++) if (at < 0 && rxq[i] === exp[0]) at = i;
      if (at < 0) begin
         chk(req, (rxq.size() > 0) ? rxq[0] : 128'bx, exp[0]);
      end else begin
         for (int k = 0; k < exp.size(); k++)
            chk(req, (at + k < rxq.size()) ? rxq[at + k] : 128'bx, exp[k]);
      end
   endtask

   task automatic t_reset();
      chk("R1 locked", {127'd0, locked}, 128'd0);
      chk("R1 tick_vld", {127'd0, tick_vld}, 128'd0);
      chk("R1 loss_cnt", {120'd0, loss_cnt}, 128'd0);
      chk("R1 err_cnt", {120'd0, err_cnt}, 128'd0);
   endtask

   task automatic t_lock();
      push_tick(MARKW, FILLW, FILLW, FILLW);
      push_tick(MARKW, FILLW, FILLW, FILLW);
      @(posedge fclk) drv_en = 1'b1;
      drain();
      chk("R2 not locked after two markers", {127'd0, locked}, 128'd0);
      repeat (12) @(negedge fclk);
      chk("R2 locked after third marker", {127'd0, locked}, 128'd1);
   endtask

   task automatic t_data(input string req);
      logic [127:0] exp[$];
      @(posedge fclk);
      rxq.delete();
      push_tick(mk(32'hC0DE0001, 4'h0, 1'b0), mk(32'hC0DE0002, 4'h0, 1'b0),
                mk(32'hC0DE0003, 4'h0, 1'b0), mk(32'hC0DE0004, 4'h0, 1'b0));
      push_tick(mk(32'hFFFFFFFF, 4'h0, 1'b0), mk(32'h00000000, 4'h0, 1'b0),
                mk(32'h12345678, 4'h2, 1'b0), mk(32'h80000001, 4'h0, 1'b0));
      push_tick(mk(32'hA5A5A5A5, 4'h1, 1'b0), mk(32'h5A5A5A5A, 4'h0, 1'b0),
                mk(32'hFFFFFFFF, 4'hF, 1'b0), mk(32'h0000BEEF, 4'h0, 1'b0));
      exp.push_back({32'hC0DE0004, 32'hC0DE0003, 32'hC0DE0002, 32'hC0DE0001});
      exp.push_back({32'h80000001, 32'h12345678, 32'h00000000, 32'hFFFFFFFF});
      exp.push_back({32'h0000BEEF, 32'hFFFFFFFF, 32'h5A5A5A5A, 32'hA5A5A5A5});
      drain();
      repeat (60) @(negedge fclk);
      chk_seq(req, exp);
   endtask

   task automatic t_restore();
      logic [127:0] exp[$];
      @(posedge fclk);
      rxq.delete();
      push_tick(mk(32'hFACE0001, 4'h0, 1'b0), mk(32'hFACE0002, 4'h0, 1'b0),
                mk(32'hFACE0003, 4'h0, 1'b0), mk(32'hFACE0004, 4'h0, 1'b0));
      push_tick(MARKW, FILLW, mk(32'h3C3C3C3C, 4'h0, 1'b0), mk(32'hBCBCBCBC, 4'h7, 1'b0));
      exp.push_back({32'hFACE0004, 32'hFACE0003, 32'hFACE0002, 32'hFACE0001});
      exp.push_back({32'hBCBCBCBC, 32'h3C3C3C3C, 32'h00000000, 32'h00000000});
      drain();
      repeat (60) @(negedge fclk);
      chk_seq("R7 comma restore", exp);
   endtask

   task automatic push_bad();
      push_tick(mk(32'h0BAD0001, 4'h0, 1'b0), mk(32'h0BAD0002, 4'h0, 1'b0),
                MARKW, mk(32'h0BAD0004, 4'h0, 1'b0));
   endtask

   task automatic t_hold();
      @(posedge fclk);
      push_bad(); push_bad();
      push_tick(MARKW, FILLW, FILLW, FILLW);
      push_bad(); push_bad();
      drain();
      chk("R4 lock kept through isolated misplaced markers", {127'd0, locked}, 128'd1);
      chk("R5 no loss counted", {120'd0, loss_cnt}, 128'd0);
   endtask

   task automatic t_loss();
      @(posedge fclk);
      push_bad(); push_bad(); push_bad();
      drain();
      chk("R4 lock dropped after limit", {127'd0, locked}, 128'd0);
      chk("R5 loss counted", {120'd0, loss_cnt}, 128'd1);
   endtask

   task automatic t_rephase();
      @(posedge fclk);
      txq.push_back(mk(32'h00C0FFEE, 4'h0, 1'b0));  // shifts the stream by one word
      drain();
      repeat (40) @(negedge fclk);
      chk("R3 relocked on shifted phase", {127'd0, locked}, 128'd1);
      t_data("R3 R6 packing after re-phase");
   endtask

   task automatic t_err();
      pulse_clr();
      @(posedge fclk);
      push_tick(mk(32'hBCBCBCBC, 4'hF, 1'b1), FILLW, FILLW, FILLW);
      push_tick(mk(32'hBCBCBCBC, 4'hF, 1'b1), mk(32'h3C3C3C3C, 4'hF, 1'b1),
                mk(32'h3C3C3C3C, 4'hF, 1'b1), mk(32'h3C3C3C3C, 4'hF, 1'b1));
      drain();
      chk("R8 five flagged words", {120'd0, err_cnt}, 128'd5);
   endtask

   task automatic t_sat();
      @(posedge fclk);
      for (int i = 0; i < 70; i++)
         push_tick(mk(32'hBCBCBCBC, 4'hF, 1'b1), mk(32'h3C3C3C3C, 4'hF, 1'b1),
                   mk(32'h3C3C3C3C, 4'hF, 1'b1), mk(32'h3C3C3C3C, 4'hF, 1'b1));
      drain();
      chk("R8 saturation", {120'd0, err_cnt}, 128'd255);
   endtask

   task automatic t_clr();
      @(posedge fclk);
      for (int i = 0; i < 20; i++)
         push_tick(mk(32'hBCBCBCBC, 4'hF, 1'b1), mk(32'h3C3C3C3C, 4'hF, 1'b1),
                   mk(32'h3C3C3C3C, 4'hF, 1'b1), mk(32'h3C3C3C3C, 4'hF, 1'b1));
      repeat (10) @(posedge fclk);
      pulse_clr();
      chk("R9 err_cnt cleared over live error", {120'd0, err_cnt}, 128'd0);
      chk("R9 loss_cnt cleared", {120'd0, loss_cnt}, 128'd0);
      drain();
   endtask

   logic finished = 1'b0;

   initial begin
      repeat (5) @(negedge fclk);
      t_reset();
      @(negedge fclk) rst_n = 1'b1;
      t_lock();
      t_data("R6 packing and order");
      t_restore();
      t_hold();
      t_loss();
      t_rephase();
      t_err();
      t_sat();
      t_clr();
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(200000 * 8);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule